// File: doc/BRIEF.md
# Serial Baud Clock Divider

This block turns the oscillator clock into the two timing strobes that an asynchronous serial port needs. The receiver gets a tick at sixteen times the bit rate for oversampling. The transmitter gets a tick at the bit rate. Software sets the rate with a 13-bit divisor BR, so the bit rate is the oscillator frequency divided by 32·BR. For example, BR = 416 with a 16 MHz oscillator gives about 1200 bit/s.

The divisor is split across two byte-wide registers on a small write/read bus. Writing the upper byte only stages it. The staged bits and the lower byte go live together on the lower-byte write, so the divider never runs with half of an old divisor and half of a new one.

The counters are held at zero, and no ticks are issued, when the divisor is zero or when both the receive and transmit enables are low. A new divisor, or a return from the idle state, starts a fresh full period.

Top module: `sci_baud_gen`

## Requirements
- R1: After reset, address 0 reads 0x00, address 1 reads 0x04, and the active divisor is 4.
- R2: Address 0 is the upper register: its bits 4:0 are divisor bits 12:8. Address 1 is the lower register and holds divisor bits 7:0. Each address reads back the value last written to it.
- R3: A write to address 0 alone leaves the active divisor, and so the tick period, unchanged.
- R4: A write to address 1 loads {staged upper bits 4:0, written byte} into the active divisor at that clock edge.
- R5: While running, `ovs_tick` is a one-cycle pulse that repeats every 2·BR clocks.
- R6: `bit_tick` is a one-cycle pulse that coincides with every 16th `ovs_tick`, giving a period of 32·BR clocks.
- R7: When the active divisor is 0, neither tick is ever asserted.
- R8: When `rx_en` and `tx_en` are both low, neither tick is ever asserted. Either enable alone is enough to run.
- R9: A divisor load, or the start of running, clears both counters. The first `ovs_tick` then appears 2·BR−1 clock edges after the load edge, or after the first edge with the enable high.
- R10: Bits 7:5 of address 0 are stored and read back but do not change the tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 upper, 1 lower |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| ovs_tick | output | 1 | 16x oversampling strobe |
| bit_tick | output | 1 | Bit-rate strobe |

## Verification
The assertions check the following on every cycle:
- a write to the upper register never moves the active divisor;
- a write to the lower register loads exactly the staged bits together with the written byte;
- no tick appears with a zero divisor or with both enables low;
- `ovs_tick` never lasts two cycles;
- `bit_tick` always lands on an `ovs_tick`.

Only the bench's scenarios can show the timing itself:
- the exact period for each divisor, from the smallest value to the largest;
- the latency of the first tick after a load or after an enable;
- that the test bits are inert;
- that register readback is correct.

// File: rtl/sci_baud_gen.sv
module sci_baud_gen #(
  parameter int DIV_W   = 13,
  parameter int OVS     = 16,
  parameter int RST_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rx_en,
  input  logic       tx_en,
  output logic       ovs_tick,
  output logic       bit_tick
);
  localparam int PW = DIV_W + 1;
  localparam int SW = $clog2(OVS);
  localparam int HW = DIV_W - 8;

  logic [7:0]       hi_q;
  logic [DIV_W-1:0] div_q;
  logic [PW-1:0]    pre_q;
  logic [SW-1:0]    sub_q;

  wire           ld      = wr_en && addr;
  wire           run     = (div_q != '0) && (rx_en || tx_en);
  wire [PW-1:0]  pre_top = {div_q, 1'b0} - PW'(1);
  wire           sub_end = (sub_q == SW'(OVS - 1));

  assign ovs_tick = run && (pre_q == pre_top);
  assign bit_tick = ovs_tick && sub_end;
  assign rdata    = addr ? div_q[7:0] : hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      div_q <= DIV_W'(RST_DIV);
    end else if (wr_en) begin
      if (!addr) hi_q  <= wdata;
      else       div_q <= {hi_q[HW-1:0], wdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (ld || !run) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (ovs_tick) begin
      pre_q <= '0;
      sub_q <= sub_end ? '0 : sub_q + SW'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end
endmodule

module sci_baud_gen_chk #(
  parameter int DIV_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             addr,
  input logic [7:0]       wdata,
  input logic             rx_en,
  input logic             tx_en,
  input logic             ovs_tick,
  input logic             bit_tick,
  input logic [7:0]       hi_q,
  input logic [DIV_W-1:0] div_q
);
  assert_hi_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr) |=> $stable(div_q));

  assert_lo_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr) |=> (div_q == {$past(hi_q[DIV_W-9:0]), $past(wdata)}));

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovs_tick |=> !ovs_tick);

  assert_bit_on_ovs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> ovs_tick);

  assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !(ovs_tick || bit_tick));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en || tx_en) |-> !(ovs_tick || bit_tick));

  assert_load_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr) |=> !ovs_tick);
endmodule

bind sci_baud_gen sci_baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rx_en(rx_en), .tx_en(tx_en), .ovs_tick(ovs_tick), .bit_tick(bit_tick),
  .hi_q(hi_q), .div_q(div_q)
);

// File: tb/sci_baud_gen_bench.sv
module sci_baud_gen_bench;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam int VBR [NV]  = '{1, 2, 3, 13, 416, 8191};
  localparam int VPER[NV]  = '{2, 4, 6, 26, 832, 16382};
  localparam bit VBIT[NV]  = '{1, 1, 1, 1, 1, 0};

  logic clk = 0, rst_n = 0, wr_en = 0, addr = 0, rx_en = 0, tx_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ovs_tick, bit_tick;
  int checks = 0, errors = 0;

  sci_baud_gen u_sci_baud_gen (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_en(rx_en), .tx_en(tx_en),
    .ovs_tick(ovs_tick), .bit_tick(bit_tick));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_ovs(output int n);
    n = 0;
    while (!ovs_tick && n < 40000) begin @(negedge clk); n++; end
  endtask

  task automatic period(output int p);
    int n;
    @(negedge clk);
    wait_ovs(n);
    p = n + 1;
  endtask

  task automatic count_ticks(input int cyc, output int t);
    t = 0;
    for (int i = 0; i < cyc; i++) begin
      if (ovs_tick || bit_tick) t++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n, p;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(0, r); check(r == 8'h00, "R1 upper reset", r, 0);
    rd(1, r); check(r == 8'h04, "R1 lower reset", r, 4);
    count_ticks(50, n); check(n == 0, "R8 idle after reset", n, 0);
    rx_en = 1;
    wait_ovs(n); check(n == 7, "R1/R9 first tick reset divisor", n, 7);
    period(p); check(p == 8, "R5 reset divisor period", p, 8);

    for (int i = 0; i < NV; i++) begin
      wr(0, 8'(VBR[i] >> 8));
      wr(1, 8'(VBR[i]));
      wait_ovs(n); check(n == VPER[i] - 1, "R9 first tick after load", n, VPER[i] - 1);
      period(p);   check(p == VPER[i], "R5 ovs period", p, VPER[i]);
      if (VBIT[i]) begin
        wr(1, 8'(VBR[i]));
        n = 0;
        while (!bit_tick && n < 40000) begin @(negedge clk); n++; end
        check(n == 16 * VPER[i] - 1, "R6 first bit tick", n, 16 * VPER[i] - 1);
        check(ovs_tick == 1, "R6 bit on ovs", ovs_tick, 1);
      end
    end

    wr(0, 8'h00); wr(1, 8'h04);
    wait_ovs(n);
    wr(0, 8'h01);
    rd(0, r); check(r == 8'h01, "R2 upper readback", r, 1);
    wait_ovs(n); period(p); check(p == 8, "R3 upper write alone", p, 8);
    wr(1, 8'h00);
    rd(1, r); check(r == 8'h00, "R2 lower readback", r, 0);
    wait_ovs(n); check(n == 511, "R4 staged load 0x100", n, 511);

    wr(0, 8'hE0); wr(1, 8'h03);
    rd(0, r); check(r == 8'hE0, "R10 test bits readback", r, 8'hE0);
    wait_ovs(n); check(n == 5, "R10 test bits inert first", n, 5);
    period(p); check(p == 6, "R10 test bits inert period", p, 6);

    wr(0, 8'h00); wr(1, 8'h00);
    count_ticks(200, n); check(n == 0, "R7 zero divisor", n, 0);

    wr(1, 8'h02);
    rx_en = 0; tx_en = 0;
    @(negedge clk);
    count_ticks(100, n); check(n == 0, "R8 both disabled", n, 0);
    tx_en = 1;
    wait_ovs(n); check(n == 3, "R9/R8 first tick after tx enable", n, 3);
    period(p); check(p == 4, "R8 tx only period", p, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule